// File: doc/BRIEF.md
# Overlapped-Fetch Instruction Cycle Sequencer

This block is the step counter and control sequencer of a multi-cycle processor with 24-bit addresses. It walks every instruction through a fetch step, a decode step and one to three execute steps, and it emits the per-step strobes: the instruction fetch, the memory address register load and the memory request. It also drives the memory address. A fetch takes its address straight from the program counter. A stack access takes its address straight from the stack pointer. Neither passes through the memory address register, so a fetch costs a single step.

When the last execute step of an ALU, MOV or load/store instruction leaves the memory address register alone, the next instruction is fetched during that step. Branch, call and return instructions never overlap, because the program counter is loaded in their last step. Back to back, ALU and MOV instructions then take two clocks, and load/store instructions take three or four.

After the synchronous reset input is released, the sequencer keeps the rest of the machine in reset for a fixed number of clocks and makes no memory requests. It then fetches from address zero.

Top module: `instr_cycle_seq`

## Requirements
- R1: After `rst` falls, `sys_rst_o` stays high for exactly 8 clocks (parameter `HOLD_CYCLES`). During those clocks `mem_req_o`, `fetch_o` and `mar_load_o` are low. In the clock after them, the first fetch is made from address 0x000000.
- R2: `step_o` is one-hot. Bit 0 is the reset hold, bit 1 is fetch, bit 2 is decode, and bits 3, 4 and 5 are execute steps 1, 2 and 3. Exactly one bit is high in every cycle.
- R3: `class_i` is sampled in every fetch cycle. The code sets the number of execute steps: 1 for 0 (ALU), 1 (MOV), 4 (jump) and 7 (spare, timed as ALU); 2 for 2 (load/store through the current MAR), 5 (call) and 6 (return); 3 for 3 (load/store with a new address).
- R4: After an instruction of class 0, 1, 2, 3 or 7, the next fetch takes place in its last execute step, with `overlap_o` high. The fetch-to-fetch spacing is then 2, 2, 3, 4 and 2 clocks.
- R5: Classes 4, 5 and 6 never overlap. In their last execute step the program counter is loaded from `target_i`, and the next fetch, from that address, follows one clock later. The fetch-to-fetch spacing is 3 for class 4 and 4 for classes 5 and 6.
- R6: In every fetch cycle `mem_req_o` is high and `addr_o` equals `pc_o`. `pc_o` then increments by one.
- R7: Class 3 raises `mar_load_o` in execute step 1, which loads `oper_addr_i` into the MAR, and makes its data request in execute step 2. Class 2 makes its data request in execute step 1. A data request drives `addr_o` from the MAR with `fetch_o` low.
- R8: Classes 5 and 6 make a data request in execute step 1, with `addr_o` equal to `sp_i` and `fetch_o` low.
- R9: An overlapped fetch never falls in a cycle that loads the MAR.
- R10: When there is neither a fetch nor a data request, `mem_req_o` is low and `addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| class_i | input | 3 | Class code of the instruction word being fetched |
| target_i | input | 24 | Branch, call or return destination |
| oper_addr_i | input | 24 | Operand address for a new-address load/store |
| sp_i | input | 24 | Current stack pointer |
| sys_rst_o | output | 1 | Reset to the rest of the machine during the hold |
| step_o | output | 6 | One-hot current step |
| fetch_o | output | 1 | Instruction fetch strobe |
| overlap_o | output | 1 | Fetch overlaps the last execute step |
| mar_load_o | output | 1 | Memory address register load strobe |
| mem_req_o | output | 1 | Memory request, fetch or data |
| addr_o | output | 24 | Memory address |
| pc_o | output | 24 | Program counter |

## Verification
Two functions can share a cycle: the last execute step of one instruction, and the fetch of the next. The bench provokes this with streams of ALU, MOV and load/store instructions. It logs the cycle, the address and the active step of each fetch, and compares the spacing between fetches and the overlap flag with the values that follow from each class. Branch, call and return sequences then show that the two functions stay in separate cycles when the program counter is being loaded. Data requests are logged against their own fetch cycle, which shows that none of them collides with a fetch.

// File: rtl/instr_cycle_seq_pkg.sv
package instr_cycle_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_EX1    = 3'd3,
        ST_EX2    = 3'd4,
        ST_EX3    = 3'd5
    } step_e;

    localparam int NUM_STEPS = 6;

    typedef enum logic [2:0] {
        IC_ALU      = 3'd0,
        IC_MOV      = 3'd1,
        IC_LS_REUSE = 3'd2,
        IC_LS_NEW   = 3'd3,
        IC_JUMP     = 3'd4,
        IC_CALL     = 3'd5,
        IC_RET      = 3'd6,
        IC_SPARE    = 3'd7
    } iclass_e;

    typedef enum logic [1:0] {
        AS_ZERO = 2'd0,
        AS_PC   = 2'd1,
        AS_SP   = 2'd2,
        AS_MAR  = 2'd3
    } asel_e;

    typedef struct packed {
        logic  fetch;
        logic  overlap;
        logic  mar_load;
        logic  data_req;
        logic  pc_load;
        asel_e asel;
    } ctl_t;

    // number of execute steps for a class
    function automatic logic [1:0] exec_len(iclass_e c);
        case (c)
            IC_LS_NEW:                     return 2'd3;
            IC_LS_REUSE, IC_CALL, IC_RET:  return 2'd2;
            default:                       return 2'd1;
        endcase
    endfunction

    // classes whose last step leaves the MAR free for an overlapped fetch
    function automatic logic may_overlap(iclass_e c);
        return !(c == IC_JUMP || c == IC_CALL || c == IC_RET);
    endfunction

    function automatic logic [1:0] ex_index(step_e s);
        case (s)
            ST_EX1:  return 2'd1;
            ST_EX2:  return 2'd2;
            ST_EX3:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/seq_hold_timer.sv
module seq_hold_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (active && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = active && (cnt == LAST);
endmodule

// File: rtl/seq_step_fsm.sv
module seq_step_fsm
    import instr_cycle_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_done,
    input  logic [2:0]  class_i,
    output step_e       step,
    output ctl_t        ctl
);
    step_e   step_nx;
    iclass_e cls;
    logic [1:0] idx;
    logic       last;

    assign idx  = ex_index(step);
    assign last = (idx != 2'd0) && (idx == exec_len(cls));

    always_comb begin
        ctl     = '0;
        step_nx = step;
        case (step)
            ST_HOLD: begin
                if (hold_done) step_nx = ST_FETCH;
            end
            ST_FETCH: begin
                ctl.fetch = 1'b1;
                ctl.asel  = AS_PC;
                step_nx   = ST_DECODE;
            end
            ST_DECODE: begin
                step_nx = ST_EX1;
            end
            default: begin
                if (cls == IC_LS_NEW && idx == 2'd1) ctl.mar_load = 1'b1;
                if ((cls == IC_LS_REUSE && idx == 2'd1) ||
                    (cls == IC_LS_NEW && idx == 2'd2)) begin
                    ctl.data_req = 1'b1;
                    ctl.asel     = AS_MAR;
                end
                if ((cls == IC_CALL || cls == IC_RET) && idx == 2'd1) begin
                    ctl.data_req = 1'b1;
                    ctl.asel     = AS_SP;
                end
                if (last) begin
                    if (may_overlap(cls)) begin
                        ctl.fetch   = 1'b1;
                        ctl.overlap = 1'b1;
                        ctl.asel    = AS_PC;
                        step_nx     = ST_DECODE;
                    end else begin
                        ctl.pc_load = 1'b1;
                        step_nx     = ST_FETCH;
                    end
                end else begin
                    case (idx)
                        2'd1:    step_nx = ST_EX2;
                        default: step_nx = ST_EX3;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_HOLD;
            cls  <= IC_ALU;
        end else begin
            step <= step_nx;
            if (ctl.fetch) cls <= iclass_e'(class_i);
        end
    end
endmodule

// File: rtl/seq_addr_path.sv
module seq_addr_path
    import instr_cycle_seq_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] oper_addr_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] mar;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= '0;
            mar <= '0;
        end else begin
            if (ctl.pc_load)      pc <= target_i;
            else if (ctl.fetch)   pc <= pc + 1'b1;
            if (ctl.mar_load)     mar <= oper_addr_i;
        end
    end

    // direct selection: fetch and stack accesses bypass the MAR
    always_comb begin
        case (ctl.asel)
            AS_PC:   addr = pc;
            AS_SP:   addr = sp_i;
            AS_MAR:  addr = mar;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import instr_cycle_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        class_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic [ADDR_W-1:0] oper_addr_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              sys_rst_o,
    output logic [5:0]        step_o,
    output logic              fetch_o,
    output logic              overlap_o,
    output logic              mar_load_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] pc_o
);
    step_e step;
    ctl_t  ctl;
    logic  hold_done;

    seq_hold_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .active (step == ST_HOLD),
        .done   (hold_done)
    );

    seq_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_done (hold_done),
        .class_i   (class_i),
        .step      (step),
        .ctl       (ctl)
    );

    seq_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .target_i    (target_i),
        .oper_addr_i (oper_addr_i),
        .sp_i        (sp_i),
        .pc          (pc_o),
        .addr        (addr_o)
    );

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign step_o[i] = (step == step_e'(i));
    end

    assign sys_rst_o  = (step == ST_HOLD);
    assign fetch_o    = ctl.fetch;
    assign overlap_o  = ctl.overlap;
    assign mar_load_o = ctl.mar_load;
    assign mem_req_o  = ctl.fetch | ctl.data_req;
endmodule

// File: rtl/instr_cycle_seq_checks.sv
module instr_cycle_seq_checks #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              sys_rst_o,
    input logic [5:0]        step_o,
    input logic              fetch_o,
    input logic              overlap_o,
    input logic              mar_load_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] pc_o
);
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> !mem_req_o && !fetch_o && !mar_load_o); // R1

    AST_FIRST_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> fetch_o && addr_o == '0); // R1

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(step_o) == 1); // R2

    AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> mem_req_o && addr_o == pc_o); // R6

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> pc_o == $past(pc_o) + 1'b1); // R6

    AST_OVERLAP_NO_MAR: assert property (@(posedge clk) disable iff (rst)
        overlap_o |-> fetch_o && !mar_load_o); // R9

    AST_OVERLAP_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        overlap_o |-> step_o[5:3] != 3'b000); // R4

    AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst)
        !mem_req_o |-> addr_o == '0); // R10
endmodule

bind instr_cycle_seq instr_cycle_seq_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .sys_rst_o  (sys_rst_o),
    .step_o     (step_o),
    .fetch_o    (fetch_o),
    .overlap_o  (overlap_o),
    .mar_load_o (mar_load_o),
    .mem_req_o  (mem_req_o),
    .addr_o     (addr_o),
    .pc_o       (pc_o)
);

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] target  = '0;
    logic [23:0] oper    = '0;
    logic [23:0] sp      = '0;
    logic [2:0]  prog [64];

    logic        sys_rst_o, fetch_o, overlap_o, mar_load_o, mem_req_o;
    logic [5:0]  step_o;
    logic [23:0] addr_o, pc_o;
    logic [2:0]  class_w;

    always #4 clk = ~clk;   // 125 MHz

    // instruction memory model
    assign class_w = prog[addr_o[5:0]];

    instr_cycle_seq uut (
        .clk(clk), .rst(rst), .class_i(class_w), .target_i(target),
        .oper_addr_i(oper), .sp_i(sp), .sys_rst_o(sys_rst_o),
        .step_o(step_o), .fetch_o(fetch_o), .overlap_o(overlap_o),
        .mar_load_o(mar_load_o), .mem_req_o(mem_req_o),
        .addr_o(addr_o), .pc_o(pc_o)
    );

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // event log, filled away from the active edge
    logic        logging = 1'b0;
    int          nf, nd, nm;
    longint      f_cyc [32];
    logic [23:0] f_addr[32];
    logic        f_ovl [32];
    logic [5:0]  f_step[32];
    longint      d_cyc [32];
    logic [23:0] d_addr[32];

    always @(negedge clk) begin
        if (logging) begin
            if (fetch_o && nf < 32) begin
                f_cyc[nf] = cyc; f_addr[nf] = addr_o;
                f_ovl[nf] = overlap_o; f_step[nf] = step_o;
                nf++;
            end
            if (mem_req_o && !fetch_o && nd < 32) begin
                d_cyc[nd] = cyc; d_addr[nd] = addr_o;
                nd++;
            end
            if (mar_load_o) nm++;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected values from the requirements
    function automatic int n_exec(int c);
        if (c == 3) return 3;
        if (c == 2 || c == 5 || c == 6) return 2;
        return 1;
    endfunction
    function automatic bit eligible(int c);
        return !(c == 4 || c == 5 || c == 6);
    endfunction
    function automatic int spacing(int c);
        return eligible(c) ? 1 + n_exec(c) : 2 + n_exec(c);
    endfunction

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 3'd0;
    endtask

    task automatic run_prog(input int n);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        nf = 0; nd = 0; nm = 0;
        logging = 1'b1;
        rst = 1'b0;
        while (nf < n) @(negedge clk);
        #1;
        logging = 1'b0;
    endtask

    // spacing, overlap flag and overlapped step for the logged fetches
    task automatic check_flow(input int n, input string req);
        for (int k = 0; k + 1 < n; k++) begin
            int c;
            c = int'(prog[f_addr[k][5:0]]);
            chk(req, $sformatf("fetch spacing after class %0d", c),
                f_cyc[k+1] - f_cyc[k], spacing(c));
            chk(req, "overlap flag", f_ovl[k+1], eligible(c));
            if (eligible(c))   // R3: overlap falls in the class's last exec step
                chk("R3", "step at overlapped fetch", f_step[k+1],
                    longint'(6'b000100) << n_exec(c));
        end
    endtask

    task automatic test_reset();
        int n;
        clear_prog();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R2", "step during reset", step_o, 6'b000001);
        chk("R1", "pc during reset", pc_o, 0);
        chk("R1", "fetch during reset", fetch_o, 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        #1;
        while (sys_rst_o && n < 100) begin
            n++;
            if (mem_req_o) chk("R1", "request during hold", mem_req_o, 0);
            @(negedge clk); #1;
        end
        chk("R1", "hold length", n, 8);
        chk("R1", "first fetch strobe", fetch_o, 1);
        chk("R1", "first fetch address", addr_o, 0);
        chk("R2", "fetch step code", step_o, 6'b000010);
        chk("R6", "memory request on fetch", mem_req_o, 1);
        @(negedge clk); #1;
        chk("R2", "decode step code", step_o, 6'b000100);
        chk("R6", "pc after fetch", pc_o, 1);
    endtask

    task automatic test_alu_stream();
        clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = (i % 3 == 0) ? 3'd0 : (i % 3 == 1) ? 3'd1 : 3'd7;
        run_prog(8);
        check_flow(8, "R4");
        for (int k = 0; k < 8; k++) chk("R6", "sequential fetch address", f_addr[k], k);
        chk("R4", "first fetch not overlapped", f_ovl[0], 0);
        chk("R10", "no data requests in alu stream", nd, 0);
    endtask

    task automatic test_ldst();
        clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = (i % 2 == 0) ? 3'd3 : 3'd2;
        oper = 24'h00ABCD;
        run_prog(6);
        check_flow(6, "R4");
        chk("R7", "data request after new-address fetch", d_cyc[0], f_cyc[0] + 3);
        chk("R7", "data request after reuse fetch", d_cyc[1], f_cyc[1] + 2);
        for (int k = 0; k < 4; k++) chk("R7", "data address from mar", d_addr[k], 24'h00ABCD);
        chk("R9", "mar loads for new-address class", nm, 3);
    endtask

    task automatic test_jump();
        clear_prog();
        prog[0] = 3'd4; prog[16] = 3'd0; prog[17] = 3'd4;
        target = 24'h000010;
        run_prog(5);
        check_flow(5, "R5");
        chk("R5", "jump destination", f_addr[1], 24'h10);
        chk("R5", "after jump target", f_addr[2], 24'h11);
        chk("R5", "loop destination", f_addr[3], 24'h10);
        chk("R3", "jump fetch spacing", f_cyc[1] - f_cyc[0], 3);
    endtask

    task automatic test_call_ret();
        clear_prog();
        prog[0] = 3'd1; prog[1] = 3'd5; prog[48] = 3'd6;
        target = 24'h000030;
        sp     = 24'h00F00D;
        run_prog(5);
        check_flow(5, "R5");
        chk("R5", "call destination", f_addr[2], 24'h30);
        chk("R5", "return destination", f_addr[3], 24'h30);
        chk("R8", "call stack access cycle", d_cyc[0], f_cyc[1] + 2);
        chk("R8", "call stack address", d_addr[0], 24'h00F00D);
        chk("R8", "return stack address", d_addr[1], 24'h00F00D);
        chk("R5", "no overlap after call", f_ovl[2], 0);
    endtask

    initial begin
        test_reset();
        test_alu_stream();
        test_ldst();
        test_jump();
        test_call_ret();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule